// File: doc/BRIEF.md
# Dual-Chip Readout Frame Capture

The block sits behind two analog-to-digital converters, one for each of two front-end readout chips that emit their serialized frames side by side. While the shared data-valid flag is high, each converter delivers one 10-bit two's complement sample per 40 MHz clock. A frame is 144 slots long. The first 16 slots are header slots, which are kept per chip in a small register bank that can be read by index. The next 128 slots are channel samples. Each channel sample is widened to a 16-bit word. The block assembles one 256-word event: all chip 0 channels come first, then all chip 1 channels. The event goes into an internal FIFO that a downstream reader drains one word per request.

Chip 0 words are written straight into the FIFO as they arrive. Chip 1 words are parked in a 128-entry stash and copied over after the frame ends. An event becomes visible to the reader only once all 256 of its words are in place. A frame that ends early is removed from the FIFO completely and raises a truncation flag. So is a frame that meets a full FIFO, which raises an overflow flag. Events committed earlier are never touched by either case. A one-cycle done pulse marks each committed event, and a word counter reports how many words of the current frame went in.

Top module: `frame_capture`

## Requirements
- R1: After reset, the FIFO reads as empty, rd_valid, frame_done, trunc_err and ovf_err are 0, and word_cnt is 0.
- R2: In each frame, slots 0 to 15 from each chip are stored, raw, in that chip's header bank at index equal to the slot number. They are read back on hdr0/hdr1 for the index on hdr_idx, and none of them reaches the FIFO.
- R3: Each channel word is the 10-bit code with bit 9 copied into bits 15:10 (for example 0x200 gives 0xFE00, 0x1FF gives 0x01FF, 0x3FF gives 0xFFFF).
- R4: An event is read out as chip 0 channels 0..127 (words 0..127), then chip 1 channels 0..127 (words 128..255). No word of it can be read before all 256 words are written. frame_done pulses high for exactly one cycle when the event is committed.
- R5: word_cnt is 256 when frame_done pulses. It is cleared to 0 when a frame starts, and set back to 0 when a frame is discarded.
- R6: If data-valid falls before all 144 slots have arrived, the partial frame is dropped from the FIFO, trunc_err goes to 1, and no frame_done pulse is produced.
- R7: If a FIFO write falls due while the FIFO is full, ovf_err goes to 1. The whole frame is dropped, with no frame_done, and every event committed earlier is still read out intact.
- R8: If data-valid stays high after slot 143, the extra slots change neither the FIFO nor the header banks. A new frame starts only after data-valid has gone low and then high again.
- R9: A read request while the FIFO is non-empty returns the oldest word on rd_data, with rd_valid high on the next cycle. A read request while the FIFO is empty is ignored, and rd_valid stays 0.
- R10: trunc_err and ovf_err hold their value until the next frame starts, and are cleared at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| dvalid | input | 1 | Frame data-valid from the front-end chips |
| adc0 | input | 10 | Chip 0 converter code, two's complement |
| adc1 | input | 10 | Chip 1 converter code, two's complement |
| rd_en | input | 1 | Read request for one event word |
| rd_data | output | 16 | Event word read from the FIFO |
| rd_valid | output | 1 | rd_data holds a word requested on the previous cycle |
| fifo_empty | output | 1 | No committed word is waiting |
| hdr_idx | input | 4 | Header bank read index |
| hdr0 | output | 10 | Chip 0 header slot at hdr_idx (registered) |
| hdr1 | output | 10 | Chip 1 header slot at hdr_idx (registered) |
| frame_done | output | 1 | One-cycle pulse when an event is committed |
| trunc_err | output | 1 | Last frame ended before slot 143 |
| ovf_err | output | 1 | Last frame hit a full FIFO |
| word_cnt | output | 9 | Words of the current frame written to the FIFO |

## Verification
The hardest case to reach is a FIFO that is exactly full when a frame's first channel word falls due. With the reader running, the FIFO drains far faster than frames arrive, so this never happens on its own. The scoreboard's reader is therefore paused while two good events fill all 512 entries. A third frame is then sent, and the bench checks that it raises the overflow flag, produces no done pulse and leaves the counter at zero. The reader is then resumed, and all 512 words must match the two earlier events. A truncated frame cut off during the header, another cut off during the channels, and a frame with data-valid held past its end each probe the discard and ignore paths.

// File: rtl/fcap_pkg.sv
package fcap_pkg;
  localparam int CHIPS = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAPT,
    ST_DRAIN,
    ST_FINISH,
    ST_HOLD
  } cap_state_e;
endpackage

// File: rtl/fcap_ram.sv
// Simple dual-port memory: one synchronous write port, one registered read port.
module fcap_ram #(
  parameter int DW = 16,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fcap_hdr_bank.sv
// Per-chip header slot registers with an indexed, registered read.
module fcap_hdr_bank #(
  parameter int DW = 10,
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ridx,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
      rdata <= '0;
    end else begin
      if (we) regs[widx] <= wdata;
      rdata <= regs[ridx];
    end
  end
endmodule

// File: rtl/fcap_fifo.sv
// FIFO with a speculative write pointer: writes land past the committed
// pointer and become readable on commit, or vanish on rollback.
module fcap_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 512
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          commit,
  input  logic          rollback,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          empty,
  output logic          full
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

  logic [AW:0] wp_spec, wp_done, rp;
  logic        do_wr, do_rd;

  assign full  = (wp_spec - rp) == FULL_LVL;
  assign empty = (wp_done == rp);
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_spec  <= '0;
      wp_done  <= '0;
      rp       <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= do_rd;
      if (do_rd) rp <= rp + 1'b1;
      if (rollback) wp_spec <= wp_done;
      else if (do_wr) wp_spec <= wp_spec + 1'b1;
      if (commit) wp_done <= wp_spec;
    end
  end

  fcap_ram #(.DW(DW), .AW(AW)) u_mem (
    .clk   (clk),
    .we    (do_wr),
    .waddr (wp_spec[AW-1:0]),
    .wdata (wr_data),
    .raddr (rp[AW-1:0]),
    .rdata (rd_data)
  );
endmodule

// File: rtl/frame_capture.sv
module frame_capture import fcap_pkg::*; #(
  parameter int SAMPLE_W   = 10,
  parameter int WORD_W     = 16,
  parameter int HDR_SLOTS  = 16,
  parameter int CH_SLOTS   = 128,
  parameter int FIFO_DEPTH = 512,
  localparam int HIDX_W    = $clog2(HDR_SLOTS),
  localparam int CNT_W     = $clog2(2*CH_SLOTS+1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dvalid,
  input  logic [SAMPLE_W-1:0] adc0,
  input  logic [SAMPLE_W-1:0] adc1,
  input  logic                rd_en,
  output logic [WORD_W-1:0]   rd_data,
  output logic                rd_valid,
  output logic                fifo_empty,
  input  logic [HIDX_W-1:0]   hdr_idx,
  output logic [SAMPLE_W-1:0] hdr0,
  output logic [SAMPLE_W-1:0] hdr1,
  output logic                frame_done,
  output logic                trunc_err,
  output logic                ovf_err,
  output logic [CNT_W-1:0]    word_cnt
);
  localparam int SLOTS  = HDR_SLOTS + CH_SLOTS;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int CH_W   = $clog2(CH_SLOTS);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
  localparam logic [SLOT_W-1:0] HDR_END   = SLOT_W'(HDR_SLOTS);
  localparam logic [CH_W:0]     DRAIN_END = (CH_W+1)'(CH_SLOTS);

  function automatic logic [WORD_W-1:0] sext(input logic [SAMPLE_W-1:0] s);
    return {{(WORD_W-SAMPLE_W){s[SAMPLE_W-1]}}, s};
  endfunction

  // Input capture stage
  logic                dv_q;
  logic [SAMPLE_W-1:0] smp_q [CHIPS];

  always_ff @(posedge clk) begin
    if (rst) begin
      dv_q <= 1'b0;
      for (int i = 0; i < CHIPS; i++) smp_q[i] <= '0;
    end else begin
      dv_q     <= dvalid;
      smp_q[0] <= adc0;
      smp_q[1] <= adc1;
    end
  end

  // Sequencer state
  cap_state_e         state;
  logic [SLOT_W-1:0]  slot;
  logic [CH_W:0]      drn_idx;
  logic               drn_pend;
  logic               ovf_q, trunc_q, done_q;
  logic [CNT_W-1:0]   wcnt_q;

  logic               take, in_hdr, in_ch;
  logic [SLOT_W-1:0]  cur_slot;
  logic [CH_W-1:0]    ch_idx;
  logic [WORD_W-1:0]  stash_rd, fifo_wdata;
  logic               wr_due, fifo_full, fifo_commit, fifo_rollback;

  assign take     = dv_q && (state == ST_IDLE || state == ST_CAPT);
  assign cur_slot = (state == ST_CAPT) ? slot : '0;
  assign in_hdr   = take && (cur_slot < HDR_END);
  assign in_ch    = take && !in_hdr;
  assign ch_idx   = CH_W'(cur_slot - HDR_END);

  assign wr_due        = in_ch || (state == ST_DRAIN && drn_pend);
  assign fifo_wdata    = in_ch ? sext(smp_q[0]) : stash_rd;
  assign fifo_commit   = (state == ST_FINISH) && !ovf_q;
  assign fifo_rollback = ((state == ST_FINISH) && ovf_q) ||
                         ((state == ST_CAPT) && !dv_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      slot     <= '0;
      drn_idx  <= '0;
      drn_pend <= 1'b0;
      ovf_q    <= 1'b0;
      trunc_q  <= 1'b0;
      done_q   <= 1'b0;
      wcnt_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (wr_due && !fifo_full) wcnt_q <= wcnt_q + 1'b1;
      if (wr_due && fifo_full)  ovf_q  <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (dv_q) begin
            state   <= ST_CAPT;
            slot    <= SLOT_W'(1);
            trunc_q <= 1'b0;
            ovf_q   <= 1'b0;
            wcnt_q  <= '0;
          end
        end
        ST_CAPT: begin
          if (!dv_q) begin
            trunc_q <= 1'b1;
            wcnt_q  <= '0;
            state   <= ST_IDLE;
          end else if (slot == LAST_SLOT) begin
            state    <= ST_DRAIN;
            drn_idx  <= '0;
            drn_pend <= 1'b0;
          end else begin
            slot <= slot + 1'b1;
          end
        end
        ST_DRAIN: begin
          if (drn_idx != DRAIN_END) begin
            drn_idx  <= drn_idx + 1'b1;
            drn_pend <= 1'b1;
          end else begin
            drn_pend <= 1'b0;
          end
          if (drn_idx == DRAIN_END && drn_pend) state <= ST_FINISH;
        end
        ST_FINISH: begin
          done_q <= !ovf_q;
          if (ovf_q) wcnt_q <= '0;
          state <= ST_HOLD;
        end
        ST_HOLD: begin
          if (!dv_q) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Header banks, one per chip
  logic [SAMPLE_W-1:0] hdr_rd [CHIPS];

  for (genvar g = 0; g < CHIPS; g++) begin : g_hdr
    fcap_hdr_bank #(.DW(SAMPLE_W), .N(HDR_SLOTS), .IW(HIDX_W)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .we    (in_hdr),
      .widx  (HIDX_W'(cur_slot)),
      .wdata (smp_q[g]),
      .ridx  (hdr_idx),
      .rdata (hdr_rd[g])
    );
  end

  // Stash for the second chip's channels until the first chip's are in
  fcap_ram #(.DW(WORD_W), .AW(CH_W)) u_stash (
    .clk   (clk),
    .we    (in_ch),
    .waddr (ch_idx),
    .wdata (sext(smp_q[CHIPS-1])),
    .raddr (CH_W'(drn_idx)),
    .rdata (stash_rd)
  );

  fcap_fifo #(.DW(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_due),
    .wr_data  (fifo_wdata),
    .commit   (fifo_commit),
    .rollback (fifo_rollback),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .empty    (fifo_empty),
    .full     (fifo_full)
  );

  assign hdr0       = hdr_rd[0];
  assign hdr1       = hdr_rd[1];
  assign frame_done = done_q;
  assign trunc_err  = trunc_q;
  assign ovf_err    = ovf_q;
  assign word_cnt   = wcnt_q;
endmodule

// File: rtl/fcap_chk.sv
module fcap_chk #(
  parameter int CH_SLOTS = 128,
  localparam int CNT_W   = $clog2(2*CH_SLOTS+1)
) (
  input logic             clk,
  input logic             rst,
  input logic             dvalid,
  input logic             rd_en,
  input logic             rd_valid,
  input logic             fifo_empty,
  input logic             frame_done,
  input logic             trunc_err,
  input logic             ovf_err,
  input logic [CNT_W-1:0] word_cnt
);
  localparam logic [CNT_W-1:0] EVT = CNT_W'(2*CH_SLOTS);

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  // R5
  done_count_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> word_cnt == EVT);

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    word_cnt <= EVT);

  // R6
  done_clean_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (!trunc_err && !ovf_err));

  // R6
  trunc_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(trunc_err) |-> !$past(dvalid, 2));

  // R9
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && fifo_empty) |=> !rd_valid);

  // R9
  valid_src_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en));
endmodule

bind frame_capture fcap_chk #(.CH_SLOTS(CH_SLOTS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .dvalid     (dvalid),
  .rd_en      (rd_en),
  .rd_valid   (rd_valid),
  .fifo_empty (fifo_empty),
  .frame_done (frame_done),
  .trunc_err  (trunc_err),
  .ovf_err    (ovf_err),
  .word_cnt   (word_cnt)
);

// File: tb/tb_frame_capture.sv
`timescale 1ns/100ps
module tb_frame_capture;
  localparam int HS = 16;
  localparam int CS = 128;
  localparam int NSLOT = HS + CS;

  logic        clk = 1'b0;
  logic        rst, dvalid, rd_en;
  logic [9:0]  adc0, adc1, hdr0, hdr1;
  logic [15:0] rd_data;
  logic        rd_valid, fifo_empty, frame_done, trunc_err, ovf_err;
  logic [3:0]  hdr_idx;
  logic [8:0]  word_cnt;

  always #2.5 clk = ~clk;

  frame_capture dut (
    .clk(clk), .rst(rst), .dvalid(dvalid), .adc0(adc0), .adc1(adc1),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .fifo_empty(fifo_empty), .hdr_idx(hdr_idx), .hdr0(hdr0), .hdr1(hdr1),
    .frame_done(frame_done), .trunc_err(trunc_err), .ovf_err(ovf_err),
    .word_cnt(word_cnt)
  );

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q[$];
  logic [9:0]  exp_h0 [HS];
  logic [9:0]  exp_h1 [HS];
  bit mon_en   = 1'b0;
  bit rd_force = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [9:0] gen(input int chip, input int s, input int seed);
    if (s == HS)     return (chip == 0) ? 10'h200 : 10'h3FF;
    if (s == HS + 1) return (chip == 0) ? 10'h1FF : 10'h200;
    if (s == HS + 2) return (chip == 0) ? 10'h3FF : 10'h1FF;
    if (s == HS + 3) return 10'h000;
    return 10'(seed * 53 + s * 29 + chip * 211 + s * s);
  endfunction

  function automatic logic [15:0] ext16(input logic [9:0] v);
    return {{6{v[9]}}, v};
  endfunction

  // Monitor: issues reads and compares returned words to the scoreboard
  always @(negedge clk) begin
    if (rst) begin
      rd_en = 1'b0;
    end else begin
      if (rd_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R4", "unexpected word", rd_data, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(rd_data == e, "R3 R4", "event word", rd_data, e);
        end
      end
      rd_en = (mon_en && !fifo_empty) || rd_force;
    end
  end

  // Driver: plays one frame, records expectations for good ones
  task automatic send_frame(input int seed, input int nslots, input int extra,
                            input bit good, input bit mid_chk);
    if (good) begin
      for (int c = 0; c < CS; c++) exp_q.push_back(ext16(gen(0, HS + c, seed)));
      for (int c = 0; c < CS; c++) exp_q.push_back(ext16(gen(1, HS + c, seed)));
      for (int h = 0; h < HS; h++) begin
        exp_h0[h] = gen(0, h, seed);
        exp_h1[h] = gen(1, h, seed);
      end
    end
    for (int s = 0; s < nslots + extra; s++) begin
      @(negedge clk);
      dvalid = 1'b1;
      adc0 = (s < NSLOT) ? gen(0, s, seed) : 10'(s * 7 + 1);
      adc1 = (s < NSLOT) ? gen(1, s, seed) : 10'(s * 11 + 3);
      if (mid_chk && s == 100)
        chk(fifo_empty == 1'b1, "R4", "words visible before commit", fifo_empty, 1);
    end
    @(negedge clk);
    dvalid = 1'b0;
    adc0 = '0;
    adc1 = '0;
  endtask

  task automatic wait_done(output bit seen, input int limit);
    seen = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (frame_done) begin
        seen = 1'b1;
        break;
      end
    end
  endtask

  task automatic drain_all();
    for (int i = 0; i < 3000; i++) begin
      if (exp_q.size() == 0 && fifo_empty) break;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R4", "words still expected", exp_q.size(), 0);
    chk(fifo_empty == 1'b1, "R8", "fifo empty after event", fifo_empty, 1);
  endtask

  task automatic check_hdr(input string tag);
    for (int i = 0; i < HS; i++) begin
      @(negedge clk);
      hdr_idx = 4'(i);
      @(negedge clk);
      @(negedge clk);
      chk(hdr0 == exp_h0[i], tag, "chip0 header", hdr0, exp_h0[i]);
      chk(hdr1 == exp_h1[i], tag, "chip1 header", hdr1, exp_h1[i]);
    end
  endtask

  task automatic good_frame(input int seed, input int extra, input bit mid_chk);
    bit seen;
    send_frame(seed, NSLOT, extra, 1'b1, mid_chk);
    wait_done(seen, 400);
    chk(seen, "R4", "done pulse", seen, 1);
    chk(word_cnt == 9'd256, "R5", "word count at done", word_cnt, 256);
    chk(!trunc_err && !ovf_err, "R10", "flags clear on good frame",
        {trunc_err, ovf_err}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit seen;
    rst = 1'b1;
    dvalid = 1'b0;
    adc0 = '0;
    adc1 = '0;
    hdr_idx = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(fifo_empty == 1'b1, "R1", "empty after reset", fifo_empty, 1);
    chk(rd_valid == 1'b0, "R1", "rd_valid after reset", rd_valid, 0);
    chk(frame_done == 1'b0, "R1", "done after reset", frame_done, 0);
    chk(!trunc_err && !ovf_err, "R1", "flags after reset", {trunc_err, ovf_err}, 0);
    chk(word_cnt == 9'd0, "R1", "count after reset", word_cnt, 0);

    // R9 read on empty
    rd_force = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(rd_valid == 1'b0, "R9", "read on empty", rd_valid, 0);
    end
    rd_force = 1'b0;
    mon_en = 1'b1;

    // Good frame, headers, ordering
    good_frame(1, 0, 1'b1);
    check_hdr("R2");
    drain_all();

    // R6 truncated in channel area, then in header area
    send_frame(2, 60, 0, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    chk(trunc_err == 1'b1, "R6", "trunc flag (channel cut)", trunc_err, 1);
    wait_done(seen, 300);
    chk(!seen, "R6", "no done on truncated frame", seen, 0);
    chk(word_cnt == 9'd0, "R5", "count after discard", word_cnt, 0);
    chk(fifo_empty == 1'b1, "R6", "no words kept", fifo_empty, 1);

    send_frame(3, 8, 0, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    chk(trunc_err == 1'b1, "R6", "trunc flag (header cut)", trunc_err, 1);
    chk(fifo_empty == 1'b1, "R6", "no words after header cut", fifo_empty, 1);

    // R10 flag cleared by next frame
    good_frame(4, 0, 1'b0);
    drain_all();

    // R8 data-valid held past the frame
    good_frame(5, 20, 1'b0);
    check_hdr("R8");
    drain_all();

    // R7 overflow with reader paused
    mon_en = 1'b0;
    repeat (4) @(negedge clk);
    good_frame(6, 0, 1'b0);
    good_frame(7, 0, 1'b0);
    chk(fifo_empty == 1'b0, "R7", "two events held", fifo_empty, 0);
    send_frame(8, NSLOT, 0, 1'b0, 1'b0);
    wait_done(seen, 400);
    chk(!seen, "R7", "no done on overflow", seen, 0);
    chk(ovf_err == 1'b1, "R7", "overflow flag", ovf_err, 1);
    chk(word_cnt == 9'd0, "R7", "count after overflow", word_cnt, 0);
    mon_en = 1'b1;
    drain_all();

    // R10 overflow flag cleared by next frame
    good_frame(9, 0, 1'b0);
    drain_all();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule